// File: doc/BRIEF.md
# UART FIFO Trigger-Level Flag Controller

This block watches the fill levels of the two byte queues of a UART, one for transmit and one for receive, each 64 entries deep. It raises two sticky status flags. The receive-level flag says that enough bytes are waiting to be read. The transmit-level flag says that the transmit queue has drained far enough to be refilled. The levels at which the flags rise come from an 8-bit control register. Each queue has its own two-bit field, and each field picks one of four fixed, non-linear thresholds.

A third field of the register turns hardware flow control on or off. When flow control is on, the clear-to-send pin passes through to the rest of the UART. The request-to-send output is then driven inactive while the receive queue is at or above its trigger. When flow control is off, both signals are held at their active level, whatever the pins do.

The queues, baud generator and serializer sit outside the block. Occupancy counts come in as ports.

Top module: `fifo_trig_flag_ctrl`

## Requirements
- R1: Control bits [7:6] pick the receive threshold. Code 00 means 1 byte, 01 means 16, 10 means 32 and 11 means 48.
- R2: Control bits [5:4] pick the transmit threshold in bytes still queued. Code 00 means 32, 01 means 16, 10 means 2 and 11 means 0, where 0 is a fully drained queue.
- R3: When `reg_we` is high, the control register loads `reg_wdata` on the clock edge, and `reg_rdata` returns all 8 bits. Bits [2:0] read back as written and change no output.
- R4: On the edge after a cycle in which `rx_count` is at or above the receive threshold, `rx_lvl_flag` is 1.
- R5: On the edge after a cycle in which `tx_count` is at or below the transmit threshold, `tx_lvl_flag` is 1.
- R6: A flag stays 1 until a clear pulse (`rx_lvl_clr` or `tx_lvl_clr`) is applied in a cycle in which its condition is false; the flag is then 0 after that edge. A clear applied while the condition holds is ignored.
- R7: With control bit 3 (flow-control enable) at 0, `cts_eff_n` is 0 and `rts_n` is 0, whatever `cts_pin_n` and the receive level are.
- R8: With control bit 3 at 1, `cts_eff_n` follows `cts_pin_n` in the same cycle. On the edge after each cycle, `rts_n` becomes 1 if `rx_count` was at or above the receive threshold, and 0 otherwise.
- R9: After reset the control register reads 0x00, so the receive threshold is 1, the transmit threshold is 32 and flow control is off. Both flags and `rts_n` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| rx_count | input | 7 | Receive queue occupancy, 0..64 |
| tx_count | input | 7 | Transmit queue occupancy, 0..64 |
| rx_lvl_clr | input | 1 | Clear request for the receive-level flag |
| tx_lvl_clr | input | 1 | Clear request for the transmit-level flag |
| cts_pin_n | input | 1 | Clear-to-send pin, active low |
| rx_lvl_flag | output | 1 | Receive level reached, sticky |
| tx_lvl_flag | output | 1 | Transmit level reached, sticky |
| cts_eff_n | output | 1 | Effective clear-to-send, active low |
| rts_n | output | 1 | Request-to-send pin, active low |

## Verification
The clear request and the set condition of a flag can arrive in the same cycle. The bench provokes this by pulsing a clear while the occupancy sits exactly on the threshold, and again while it sits one step past the threshold. It judges that the flag stays 1 in both cases, and that the same clear applied one step short of the threshold brings the flag to 0. A register write that lands in the same cycle as a count change is also checked: the flag must follow the old threshold for that edge and the new threshold on the next.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;

    typedef struct packed {
        logic [1:0] rx_sel;
        logic [1:0] tx_sel;
        logic       fc_en;
        logic [2:0] spare;
    } ctrl_t;

    // receive threshold in bytes for a depth-DEPTH queue
    function automatic int rx_level(input logic [1:0] sel, input int depth);
        case (sel)
            2'b00:   return 1;
            2'b01:   return depth / 4;
            2'b10:   return depth / 2;
            default: return (3 * depth) / 4;
        endcase
    endfunction

    // transmit threshold in bytes still queued
    function automatic int tx_level(input logic [1:0] sel, input int depth);
        case (sel)
            2'b00:   return depth / 2;
            2'b01:   return depth / 4;
            2'b10:   return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/fifo_level_cmp.sv
module fifo_level_cmp #(
    parameter int DEPTH = 64,
    parameter bit IS_RX = 1'b1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [1:0]    sel,
    input  logic [CW-1:0] count,
    output logic          hit
);
    import fifo_trig_pkg::*;

    logic [CW-1:0] thr;

    generate
        if (IS_RX) begin : g_rx
            always_comb begin
                thr = CW'(rx_level(sel, DEPTH));
                hit = (count >= thr);
            end
        end else begin : g_tx
            always_comb begin
                thr = CW'(tx_level(sel, DEPTH));
                hit = (count <= thr);
            end
        end
    endgenerate

endmodule

// File: rtl/modem_gate.sv
module modem_gate (
    input  logic fc_en,
    input  logic cts_pin_n,
    input  logic rx_hit,
    output logic cts_eff_n,
    output logic rts_n_d
);
    always_comb begin
        cts_eff_n = fc_en ? cts_pin_n : 1'b0;
        rts_n_d   = fc_en ? rx_hit    : 1'b0;
    end
endmodule

// File: rtl/fifo_trig_flag_ctrl.sv
module fifo_trig_flag_ctrl #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          rx_lvl_clr,
    input  logic          tx_lvl_clr,
    input  logic          cts_pin_n,
    output logic          rx_lvl_flag,
    output logic          tx_lvl_flag,
    output logic          cts_eff_n,
    output logic          rts_n
);
    import fifo_trig_pkg::*;

    typedef struct packed {
        ctrl_t ctrl;
        logic  rx_flag;
        logic  tx_flag;
        logic  rts_n;
    } state_t;

    state_t st_d, st_q;
    logic   rx_hit, tx_hit, rts_n_nx;

    fifo_level_cmp #(.DEPTH(DEPTH), .IS_RX(1'b1)) rx_cmp_i (
        .sel   (st_q.ctrl.rx_sel),
        .count (rx_count),
        .hit   (rx_hit)
    );

    fifo_level_cmp #(.DEPTH(DEPTH), .IS_RX(1'b0)) tx_cmp_i (
        .sel   (st_q.ctrl.tx_sel),
        .count (tx_count),
        .hit   (tx_hit)
    );

    modem_gate gate_i (
        .fc_en     (st_q.ctrl.fc_en),
        .cts_pin_n (cts_pin_n),
        .rx_hit    (rx_hit),
        .cts_eff_n (cts_eff_n),
        .rts_n_d   (rts_n_nx)
    );

    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            st_d.ctrl = ctrl_t'(reg_wdata);
        end
        // condition wins over a clear arriving in the same cycle
        st_d.rx_flag = rx_hit | (st_q.rx_flag & ~rx_lvl_clr);
        st_d.tx_flag = tx_hit | (st_q.tx_flag & ~tx_lvl_clr);
        st_d.rts_n   = rts_n_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata   = st_q.ctrl;
    assign rx_lvl_flag = st_q.rx_flag;
    assign tx_lvl_flag = st_q.tx_flag;
    assign rts_n       = st_q.rts_n;

endmodule

// File: rtl/fifo_trig_flag_ctrl_chk.sv
module fifo_trig_flag_ctrl_chk #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    reg_rdata,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic          rx_lvl_clr,
    input logic          tx_lvl_clr,
    input logic          cts_pin_n,
    input logic          rx_lvl_flag,
    input logic          tx_lvl_flag,
    input logic          cts_eff_n,
    input logic          rts_n
);
    import fifo_trig_pkg::*;

    logic rx_at, tx_at;
    always_comb begin
        rx_at = int'(rx_count) >= rx_level(reg_rdata[7:6], DEPTH);
        tx_at = int'(tx_count) <= tx_level(reg_rdata[5:4], DEPTH);
    end

    // R4
    p_rx_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_at |=> rx_lvl_flag);

    // R5
    p_tx_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_at |=> tx_lvl_flag);

    // R6: flags hold without a clear
    p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_lvl_flag && !rx_lvl_clr) |=> rx_lvl_flag);

    p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lvl_flag && !tx_lvl_clr) |=> tx_lvl_flag);

    // R7
    p_cts_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[3] |-> !cts_eff_n);

    p_rts_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[3] |=> !rts_n);

    // R8
    p_cts_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[3] |-> (cts_eff_n == cts_pin_n));

    p_rts_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[3] |=> (rts_n == $past(rx_at)));

endmodule

bind fifo_trig_flag_ctrl fifo_trig_flag_ctrl_chk #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rdata   (reg_rdata),
    .rx_count    (rx_count),
    .tx_count    (tx_count),
    .rx_lvl_clr  (rx_lvl_clr),
    .tx_lvl_clr  (tx_lvl_clr),
    .cts_pin_n   (cts_pin_n),
    .rx_lvl_flag (rx_lvl_flag),
    .tx_lvl_flag (tx_lvl_flag),
    .cts_eff_n   (cts_eff_n),
    .rts_n       (rts_n)
);

// File: tb/fifo_trig_flag_ctrl_tb.sv
`timescale 1ns/1ps
module fifo_trig_flag_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [6:0] rx_count = '0;
    logic [6:0] tx_count = 7'd64;
    logic       rx_lvl_clr = 1'b0;
    logic       tx_lvl_clr = 1'b0;
    logic       cts_pin_n = 1'b1;
    logic       rx_lvl_flag, tx_lvl_flag, cts_eff_n, rts_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fifo_trig_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_count(rx_count), .tx_count(tx_count),
        .rx_lvl_clr(rx_lvl_clr), .tx_lvl_clr(tx_lvl_clr), .cts_pin_n(cts_pin_n),
        .rx_lvl_flag(rx_lvl_flag), .tx_lvl_flag(tx_lvl_flag),
        .cts_eff_n(cts_eff_n), .rts_n(rts_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive at negedge, sample 1 ns after the following posedge
    task automatic step(input int rxc, input int txc, input bit rclr, input bit tclr);
        @(negedge clk);
        rx_count   = 7'(rxc);
        tx_count   = 7'(txc);
        rx_lvl_clr = rclr;
        tx_lvl_clr = tclr;
        @(posedge clk);
        #1;
        rx_lvl_clr = 1'b0;
        tx_lvl_clr = 1'b0;
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = v;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R9", "ctrl after reset", int'(reg_rdata), 0);
        check("R9", "rx flag after reset", int'(rx_lvl_flag), 0);
        check("R9", "tx flag after reset", int'(tx_lvl_flag), 0);
        check("R9", "rts after reset", int'(rts_n), 0);
        check("R7", "cts forced after reset", int'(cts_eff_n), 0);
    endtask

    task automatic t_register();
        wr(8'hA5);
        check("R3", "readback A5", int'(reg_rdata), 8'hA5);
        wr(8'h07);
        check("R3", "readback 07", int'(reg_rdata), 8'h07);
        // spare bits alone change no output
        step(0, 64, 1'b1, 1'b1);
        check("R3", "rx flag with spare bits", int'(rx_lvl_flag), 0);
        check("R3", "cts with spare bits", int'(cts_eff_n), 0);
        check("R3", "rts with spare bits", int'(rts_n), 0);
    endtask

    task automatic t_rx_levels();
        int thr[4] = '{1, 16, 32, 48};
        for (int c = 0; c < 4; c++) begin
            wr(8'(c << 6));
            step(thr[c] - 1, 64, 1'b1, 1'b0);
            check("R1", $sformatf("rx below code %0d", c), int'(rx_lvl_flag), 0);
            step(thr[c], 64, 1'b0, 1'b0);
            check("R4", $sformatf("rx at code %0d", c), int'(rx_lvl_flag), 1);
        end
    endtask

    task automatic t_tx_levels();
        int thr[4] = '{32, 16, 2, 0};
        for (int c = 0; c < 4; c++) begin
            wr(8'(c << 4));
            step(0, thr[c] + 1, 1'b1, 1'b1);
            check("R2", $sformatf("tx above code %0d", c), int'(tx_lvl_flag), 0);
            step(0, thr[c], 1'b0, 1'b0);
            check("R5", $sformatf("tx at code %0d", c), int'(tx_lvl_flag), 1);
        end
    endtask

    task automatic t_clear();
        wr(8'h40); // rx threshold 16
        step(16, 64, 1'b0, 1'b0);
        check("R6", "rx set", int'(rx_lvl_flag), 1);
        step(16, 64, 1'b1, 1'b0);
        check("R6", "clear at threshold ignored", int'(rx_lvl_flag), 1);
        step(17, 64, 1'b1, 1'b0);
        check("R6", "clear above threshold ignored", int'(rx_lvl_flag), 1);
        step(15, 64, 1'b0, 1'b0);
        check("R6", "sticky without clear", int'(rx_lvl_flag), 1);
        step(15, 64, 1'b1, 1'b0);
        check("R6", "clear below threshold", int'(rx_lvl_flag), 0);
        step(15, 0, 1'b0, 1'b1);
        check("R6", "tx clear while drained ignored", int'(tx_lvl_flag), 1);
        // write and count change in the same cycle: old threshold 16 on this edge
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = 8'h00; rx_count = 7'd2;
        @(posedge clk); #1;
        reg_we = 1'b0;
        check("R4", "old threshold on write edge", int'(rx_lvl_flag), 0);
        step(2, 64, 1'b0, 1'b0);
        check("R4", "new threshold after write", int'(rx_lvl_flag), 1);
    endtask

    task automatic t_modem();
        wr(8'h00);
        @(negedge clk); cts_pin_n = 1'b1; #1;
        check("R7", "cts forced low", int'(cts_eff_n), 0);
        step(1, 64, 1'b0, 1'b0);
        check("R7", "rts forced low at level", int'(rts_n), 0);
        wr(8'h88); // rx threshold 32, flow control on
        @(negedge clk); cts_pin_n = 1'b1; #1;
        check("R8", "cts passes high", int'(cts_eff_n), 1);
        @(negedge clk); cts_pin_n = 1'b0; #1;
        check("R8", "cts passes low", int'(cts_eff_n), 0);
        step(31, 64, 1'b0, 1'b0);
        check("R8", "rts active below level", int'(rts_n), 0);
        step(32, 64, 1'b0, 1'b0);
        check("R8", "rts inactive at level", int'(rts_n), 1);
        step(5, 64, 1'b0, 1'b0);
        check("R8", "rts active again", int'(rts_n), 0);
        step(40, 64, 1'b0, 1'b0);
        wr(8'h80);
        @(negedge clk); cts_pin_n = 1'b1; #1;
        check("R7", "cts forced after disable", int'(cts_eff_n), 0);
        step(40, 64, 1'b0, 1'b0);
        check("R7", "rts forced after disable", int'(rts_n), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_register();
        t_rx_levels();
        t_tx_levels();
        t_clear();
        t_modem();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule